// File: doc/BRIEF.md
# I2S to Burst-Mode DAC Formatter

This block sits between an I2S source and a simultaneous-input audio DAC. The source sends 16-bit two's-complement stereo samples in 64-bit frames, with 32 bit clocks per channel. The block regenerates the bit clock for the DAC in short bursts of exactly 16 pulses per stereo frame. It keeps the DAC-side clock, data and latch lines static for the rest of the frame. This gives the converter a long quiet interval in every sample period.

The block converts each sample to offset binary while it streams through, by flipping only its first (most significant) bit. The left channel passes through a one-slot delay line, so its bits come out on their own data line in step with the right channel's bits. A single latch-enable pulse, one bit clock long, comes just before the first bit of each burst.

All logic runs on a fast system clock that oversamples the incoming bit clock. The DAC-side clock is a registered signal whose enable changes only while that clock is low. After reset the outputs stay idle until the start of a left slot has been seen, so the first burst the DAC receives is always complete.

Top module: `i2sb_burst_formatter`

## Requirements
- R1: Exactly 16 rising edges of `dac_bck` occur per stereo frame, all of them inside the right-channel slot (`i2s_ws` = 1). `dac_bck` is low at every other time.
- R2: A slot counter, advanced on each rising edge of `i2s_bck`, is cleared by the first rising edge that sees a changed `i2s_ws`. The word's most significant bit is taken at the next rising edge, so a slot of any length before the first frame does not shift the word boundaries.
- R3: The word on each data line equals the input sample plus 32768 modulo 65536: only its first bit is inverted, and the other 15 bits pass unchanged. It is transmitted first bit first, one bit per `dac_bck` rising edge.
- R4: `dac_le` is high for exactly one input bit-clock period, and `dac_bck` stays low while it is high. It falls less than one bit-clock period before the first `dac_bck` rising edge of the burst.
- R5: The left word of a frame appears on `dac_data_l` in the same burst as the right word of that frame on `dac_data_r`. To achieve this, left bits are delayed by 32 input bit clocks.
- R6: Outside a burst, `dac_data_l`, `dac_data_r` and `dac_bck` are all 0, and so are all outputs after reset.
- R7: Until a falling edge of `i2s_ws` (start of a left slot) has been seen after reset, no `dac_bck` edge and no `dac_le` pulse is produced.
- R8: `dac_data_l` and `dac_data_r` are stable for as long as `dac_bck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples `i2s_bck` at least 6 times |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | Incoming I2S bit clock |
| i2s_ws | input | 1 | Incoming word select, 0 = left, 1 = right |
| i2s_sd | input | 1 | Incoming serial data, changes on falling `i2s_bck` |
| dac_bck | output | 1 | Gated DAC bit clock, 16 pulses per frame |
| dac_le | output | 1 | Latch-enable pulse before each burst |
| dac_data_l | output | 1 | Left offset-binary bits, aligned with the right bits |
| dac_data_r | output | 1 | Right offset-binary bits |

## Verification
An input rising edge appears on `dac_bck` three system clocks later: two synchroniser stages and the output register. Data and `dac_le` change four system clocks after an input falling edge. The bench never predicts these offsets edge by edge. Instead it samples on the falling system clock and takes each data bit at the rising edge of `dac_bck` itself. It measures the latch pulse and the gap to the first pulse in whole system clocks against one bit-clock period. Word comparisons happen at the 16th pulse of burst k, against frame k, because the left delay makes both words of a frame land in the right slot of that same frame.

// File: rtl/i2sb_pkg.sv
package i2sb_pkg;

  // Slot position that carries the first (sign) bit of the word.
  function automatic bit is_sign_pos(input int unsigned pos);
    return pos == 1;
  endfunction

  // Slot position during which the latch pulse is launched.
  function automatic bit is_latch_pos(input int unsigned pos);
    return pos == 0;
  endfunction

  // Positions whose bits are forwarded with a clock pulse.
  function automatic bit is_word_pos(input int unsigned pos, input int unsigned word_bits);
    return (pos >= 1) && (pos <= word_bits);
  endfunction

endpackage

// File: rtl/i2sb_sync.sv
module i2sb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2sb_slot_counter.sv
module i2sb_slot_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             ws,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] pos_nxt,
  output logic             ws_q,
  output logic             armed
);
  logic ws_change;

  assign ws_change = ws != ws_q;
  assign pos_nxt   = ws_change ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      ws_q  <= 1'b0;
      armed <= 1'b0;
    end else if (rise) begin
      pos  <= pos_nxt;
      ws_q <= ws;
      if (ws_change && !ws) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/i2sb_delay.sv
module i2sb_delay #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (shift) sr <= {sr[DEPTH-2:0], din};
  end

  assign dout = sr[DEPTH-1];
endmodule

// File: rtl/i2sb_burst_formatter.sv
module i2sb_burst_formatter
  import i2sb_pkg::*;
#(
  parameter int   WORD_BITS   = 16,
  parameter int   SLOT_BITS   = 32,
  parameter int   SYNC_STAGES = 2,
  parameter logic RIGHT_WS    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bck,
  output logic dac_le,
  output logic dac_data_l,
  output logic dac_data_r
);
  localparam int CNT_W = $clog2(SLOT_BITS);

  logic             bck_s, ws_s, sd_s, bck_d;
  logic             bck_rise, bck_fall, launch;
  logic [CNT_W-1:0] pos, pos_nxt;
  logic             ws_q, armed;
  logic             sign_here, conv_bit, dly_out;
  logic             left_bit, right_bit;
  logic             in_right, burst_go, latch_go;
  logic             burst_en;

  i2sb_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({i2s_bck, i2s_ws, i2s_sd}),
    .q({bck_s, ws_s, sd_s})
  );

  assign bck_rise = bck_s & ~bck_d;
  assign bck_fall = ~bck_s & bck_d;

  i2sb_slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(bck_rise), .ws(ws_s),
    .pos(pos), .pos_nxt(pos_nxt), .ws_q(ws_q), .armed(armed)
  );

  assign sign_here = is_sign_pos(int'(pos_nxt));
  assign conv_bit  = sd_s ^ sign_here;

  i2sb_delay #(.DEPTH(SLOT_BITS)) u_left_dly (
    .clk(clk), .rst_n(rst_n), .shift(bck_rise), .din(conv_bit), .dout(dly_out)
  );

  assign in_right = armed && (ws_q == RIGHT_WS);
  assign burst_go = in_right && is_word_pos(int'(pos), WORD_BITS);
  assign latch_go = in_right && is_latch_pos(int'(pos));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_d     <= 1'b0;
      launch    <= 1'b0;
      left_bit  <= 1'b0;
      right_bit <= 1'b0;
      burst_en  <= 1'b0;
      dac_le    <= 1'b0;
      dac_data_l <= 1'b0;
      dac_data_r <= 1'b0;
      dac_bck   <= 1'b0;
    end else begin
      bck_d   <= bck_s;
      launch  <= bck_fall;
      dac_bck <= burst_en & bck_s;
      if (bck_rise) begin
        right_bit <= conv_bit;
        left_bit  <= dly_out;
      end
      if (launch) begin
        burst_en   <= burst_go;
        dac_le     <= latch_go;
        dac_data_l <= burst_go & left_bit;
        dac_data_r <= burst_go & right_bit;
      end
    end
  end
endmodule

// File: rtl/i2sb_burst_formatter_chk.sv
module i2sb_burst_formatter_chk #(
  parameter int WORD_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic dac_bck,
  input logic dac_le,
  input logic dac_data_l,
  input logic dac_data_r,
  input logic burst_en,
  input logic armed
);
  logic       bck_prev;
  logic [7:0] pulses;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_prev <= 1'b0;
      pulses   <= '0;
    end else begin
      bck_prev <= dac_bck;
      if (dac_le)                   pulses <= '0;
      else if (dac_bck && !bck_prev) pulses <= pulses + 1'b1;
    end
  end

  assert_pulse_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_bck && !bck_prev) |-> (pulses < 8'(WORD_BITS)));

  assert_le_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_le |-> !dac_bck);

  assert_le_then_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_le) |-> burst_en);

  assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |-> (!dac_bck && !dac_data_l && !dac_data_r));

  assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!dac_bck && !dac_le));

  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dac_bck |-> ($stable(dac_data_l) && $stable(dac_data_r)));
endmodule

bind i2sb_burst_formatter i2sb_burst_formatter_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_bck(dac_bck), .dac_le(dac_le),
  .dac_data_l(dac_data_l), .dac_data_r(dac_data_r),
  .burst_en(burst_en), .armed(armed)
);

// File: tb/tb_i2sb_burst_formatter.sv
module tb_i2sb_burst_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 4;
  localparam int BCK_CLKS   = 2 * HALF_BCK;
  localparam int FRAMES     = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b1, i2s_sd = 1'b0;
  logic dac_bck, dac_le, dac_data_l, dac_data_r;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2sb_burst_formatter dut (
    .clk(clk), .rst_n(rst_n), .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .dac_bck(dac_bck), .dac_le(dac_le), .dac_data_l(dac_data_l), .dac_data_r(dac_data_r)
  );

  function automatic logic [15:0] samp(input int k, input bit right);
    int v;
    case (k)
      0: v = right ? 16'h8000 : 16'h0000;
      1: v = right ? 16'h0000 : 16'h7FFF;
      2: v = right ? 16'hFFFF : 16'h8000;
      3: v = right ? 16'h0001 : 16'hFFFF;
      4: v = right ? 16'h5A5A : 16'hA5A5;
      default: v = right ? (k * 40503 + 12345) : (k * 25173 + 13849);
    endcase
    return v[15:0];
  endfunction

  function automatic logic [15:0] offset_of(input logic [15:0] w);
    int s;
    s = (int'(w) + 32768) % 65536;
    return s[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bck_cycle(input logic ws, input logic sd);
    @(negedge clk);
    i2s_bck = 1'b0; i2s_ws = ws; i2s_sd = sd;
    repeat (HALF_BCK) @(negedge clk);
    i2s_bck = 1'b1;
    repeat (HALF_BCK - 1) @(negedge clk);
  endtask

  // monitor state
  bit prev_bck = 0, prev_le = 0, started = 0, wait_first = 0;
  int pulses = 0, bursts = 0, le_len = 0, gap = 0, total_rises = 0, le_count = 0;
  logic [15:0] wl = '0, wr = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dac_le) le_len++;
      if (wait_first) gap++;
      if (dac_le && !prev_le) begin
        le_count++;
        check(!dac_bck && !dac_data_l && !dac_data_r, "R6 idle before burst",
              {dac_bck, dac_data_l, dac_data_r}, 0);
        if (started) check(pulses == 16, "R1 pulses per frame", pulses, 16);
      end
      if (!dac_le && prev_le) begin
        check(le_len == BCK_CLKS, "R4 latch width", le_len, BCK_CLKS);
        le_len = 0; pulses = 0; wl = '0; wr = '0; gap = 0;
        started = 1; wait_first = 1;
      end
      if (dac_bck && !prev_bck) begin
        total_rises++;
        if (wait_first) begin
          check(gap < BCK_CLKS, "R4 latch to first pulse", gap, BCK_CLKS);
          wait_first = 0;
        end
        pulses++;
        wl = {wl[14:0], dac_data_l};
        wr = {wr[14:0], dac_data_r};
        if (pulses == 16) begin
          check(wl == offset_of(samp(bursts, 0)), "R5 R3 left word", wl, offset_of(samp(bursts, 0)));
          check(wr == offset_of(samp(bursts, 1)), "R3 R2 right word", wr, offset_of(samp(bursts, 1)));
          bursts++;
        end
      end
      prev_bck = dac_bck;
      prev_le  = dac_le;
    end
  end

  initial begin
    logic prev_lsb;
    logic [15:0] w;
    repeat (10) @(negedge clk);
    check(!dac_bck && !dac_le && !dac_data_l && !dac_data_r, "R6 reset state",
          {dac_bck, dac_le, dac_data_l, dac_data_r}, 0);
    rst_n = 1'b1;
    // short, unaligned right slot before the first left slot: resync R2, quiet R7
    for (int j = 0; j < 20; j++) bck_cycle(1'b1, logic'(j % 3 == 0));
    check(total_rises == 0 && le_count == 0, "R7 quiet before arming", total_rises + le_count, 0);
    prev_lsb = 1'b1;
    for (int k = 0; k < FRAMES; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        w = samp(k, ch == 1);
        for (int j = 0; j < 32; j++)
          bck_cycle(logic'(ch), (j == 0) ? prev_lsb : ((j <= 16) ? w[16 - j] : 1'b0));
        prev_lsb = w[0];
      end
    end
    for (int j = 0; j < 32; j++) bck_cycle(1'b0, (j == 0) ? prev_lsb : 1'b0);
    repeat (20) @(negedge clk);
    check(bursts == FRAMES, "R1 burst count", bursts, FRAMES);
    check(pulses == 16, "R1 last burst pulses", pulses, 16);
    check(total_rises == 16 * FRAMES, "R1 total pulses", total_rises, 16 * FRAMES);
    check(le_count == FRAMES, "R4 latch count", le_count, FRAMES);
    check(!dac_bck && !dac_data_l && !dac_data_r && !dac_le, "R6 idle after stream",
          {dac_bck, dac_data_l, dac_data_r, dac_le}, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule